// File: doc/BRIEF.md
# Automatic Modem-Line Flow Controller

This block paces a serial link in both directions, using one pair of active-low modem-control lines. On the receive side it compares the fill level of a 32-entry receive FIFO against a programmable trigger level. When the FIFO grows past that level, it drives the flow-control output high to ask the far end to pause. It lets the output fall again only after the FIFO has drained below the trigger level minus a programmable hysteresis amount. This gap stops the line from toggling on every byte.

On the transmit side it watches an active-low permission input from the far end through a two-flop synchronizer. It raises a hold signal that the transmit engine obeys before it starts the next character. The hold is never raised in the middle of a character: the block waits for the transmitter's stop-bit-done strobe. The hold is released as soon as the far end lowers the line again.

A pair-select input chooses which line pair carries the handshake: the request/clear pair or the terminal-ready/set-ready pair. Any transition on the monitored input sets a change-of-state flag. The host clears this flag by reading its modem status register. The FIFO storage and the serial shifter sit outside this block.

Top module: `hwflow_ctrl`

## Requirements
- R1: While automatic receive pacing is enabled, the active flow output (`rts_n_out` when `cfg_pair_sel`=0) goes high one clock edge after `rx_fifo_lvl` becomes strictly greater than `cfg_trig_lvl`. The level input covers 0 to 32.
- R2: Once high, the flow output returns low only after `rx_fifo_lvl` is strictly below the resume level. The resume level is `cfg_trig_lvl - cfg_hyst`, or 1 when that difference is below 1. Between the resume level and the trigger level the output keeps its previous value.
- R3: While `cfg_auto_rts_en`=0, the flow output is the inverse of its software bit (`sw_rts`, or `sw_dtr` for the other pair). The paused state is cleared, so re-enabling starts from the running state.
- R4: Both monitored inputs pass through a two-flop synchronizer. With `cfg_auto_cts_en`=1 and no character in progress, a high level on the monitored input raises `tx_hold` on the third clock edge after the pin changes.
- R5: While `tx_char_busy`=1, `tx_hold` rises only in the cycle in which `tx_stop_done`=1. It never rises in the middle of a character.
- R6: `tx_hold` falls on the third edge after the monitored pin returns low. It also falls one edge after `cfg_auto_cts_en` is cleared.
- R7: Any transition of the synchronized monitored input sets `cos_flag` on the third edge after the pin change. A set in the same cycle as a clear wins.
- R8: A one-cycle pulse on `msr_read` clears `cos_flag` on the next edge.
- R9: With `cfg_pair_sel`=1, `dtr_n_out` carries the fill-level pacing and `dsr_n_in` is monitored. `rts_n_out` follows `~sw_rts`, and `cts_n_in` has no effect on `tx_hold` or `cos_flag`.
- R10: After synchronous reset, `tx_hold`=0 and `cos_flag`=0, and the pacing state is running. A flow output under automatic control is therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pair_sel | input | 1 | 0: request/clear pair, 1: terminal-ready/set-ready pair |
| cfg_auto_rts_en | input | 1 | Enable automatic receive pacing |
| cfg_auto_cts_en | input | 1 | Enable automatic transmit gating |
| cfg_trig_lvl | input | 6 | Receive trigger level |
| cfg_hyst | input | 6 | Hysteresis amount below the trigger |
| sw_rts | input | 1 | Software request bit (1 = assert, pin low) |
| sw_dtr | input | 1 | Software terminal-ready bit (1 = assert, pin low) |
| rx_fifo_lvl | input | 6 | Receive FIFO fill level, 0 to 32 |
| cts_n_in | input | 1 | Asynchronous clear input, active low |
| dsr_n_in | input | 1 | Asynchronous set-ready input, active low |
| tx_char_busy | input | 1 | Transmitter is shifting a character |
| tx_stop_done | input | 1 | Strobe: stop bit of current character finished |
| msr_read | input | 1 | Host read of modem status, clears the flag |
| rts_n_out | output | 1 | Request output, active low |
| dtr_n_out | output | 1 | Terminal-ready output, active low |
| tx_hold | output | 1 | Transmitter must not start a new character |
| cos_flag | output | 1 | Change-of-state interrupt flag |

## Verification
Several properties are checked on every cycle. The pause output is asserted after an over-trigger level and kept while the level stays at or above the trigger. The hold never rises during a character without the stop strobe, and it drops once permission returns. Every synchronized edge sets the flag, and a read without an edge clears it. Other behaviour can only be shown by the bench's scenarios: the exact resume point inside the hysteresis band, the clamped resume level, the three-edge latency through the synchronizer, set-over-clear priority, and the pair-select case where the unused input is ignored.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;

    localparam int FIFO_DEPTH_DEF  = 32;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic {
        PAIR_REQ_CLR = 1'b0,
        PAIR_TRM_SET = 1'b1
    } pair_sel_e;

    typedef enum logic {
        FLOW_RUN    = 1'b0,
        FLOW_PAUSED = 1'b1
    } flow_state_e;

    typedef struct packed {
        logic busy;
        logic stop_done;
    } tx_status_t;

    // Boundary test: may the transmit hold change state in this cycle?
    function automatic logic at_char_boundary(input tx_status_t st);
        return !st.busy || st.stop_done;
    endfunction

endpackage

// File: rtl/hwflow_sync.sv
module hwflow_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= RST_VAL;
                    else     chain_q[i] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= RST_VAL;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hwflow_rx_pace.sv
module hwflow_rx_pace
    import hwflow_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic [LVL_W-1:0] fifo_lvl,
    input  logic [LVL_W-1:0] trig_lvl,
    input  logic [LVL_W-1:0] hyst,
    output flow_state_e      state
);
    logic [LVL_W-1:0] resume_lvl;

    // Resume level is clamped to 1 so an empty FIFO always restarts the far end.
    always_comb begin
        if (trig_lvl > hyst) resume_lvl = trig_lvl - hyst;
        else                 resume_lvl = LVL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !auto_en)          state <= FLOW_RUN;
        else if (fifo_lvl > trig_lvl) state <= FLOW_PAUSED;
        else if (fifo_lvl < resume_lvl) state <= FLOW_RUN;
    end
endmodule

// File: rtl/hwflow_tx_gate.sv
module hwflow_tx_gate
    import hwflow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       auto_en,
    input  logic       mon_high,
    input  tx_status_t tx_st,
    output logic       hold
);
    logic want_hold;

    assign want_hold = auto_en && mon_high;

    always_ff @(posedge clk) begin
        if (rst || !want_hold)           hold <= 1'b0;
        else if (at_char_boundary(tx_st)) hold <= 1'b1;
    end
endmodule

// File: rtl/hwflow_cos.sv
module hwflow_cos
    import hwflow_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pair_sel_e sel,
    input  logic      mon_a,
    input  logic      mon_b,
    input  logic      clr,
    output logic      edge_seen,
    output logic      flag
);
    logic prev_a, prev_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= mon_a;
            prev_b <= mon_b;
        end
    end

    assign edge_seen = (sel == PAIR_TRM_SET) ? (mon_b ^ prev_b) : (mon_a ^ prev_a);

    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (edge_seen) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end
endmodule

// File: rtl/hwflow_ctrl.sv
module hwflow_ctrl
    import hwflow_pkg::*;
#(
    parameter int FIFO_DEPTH  = FIFO_DEPTH_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_pair_sel,
    input  logic             cfg_auto_rts_en,
    input  logic             cfg_auto_cts_en,
    input  logic [LVL_W-1:0] cfg_trig_lvl,
    input  logic [LVL_W-1:0] cfg_hyst,
    input  logic             sw_rts,
    input  logic             sw_dtr,
    input  logic [LVL_W-1:0] rx_fifo_lvl,
    input  logic             cts_n_in,
    input  logic             dsr_n_in,
    input  logic             tx_char_busy,
    input  logic             tx_stop_done,
    input  logic             msr_read,
    output logic             rts_n_out,
    output logic             dtr_n_out,
    output logic             tx_hold,
    output logic             cos_flag
);
    localparam int N_LANES = 2;

    pair_sel_e    sel;
    flow_state_e  pace_state;
    tx_status_t   tx_st;
    logic [N_LANES-1:0] pin_n;
    logic [N_LANES-1:0] mon_sync;
    logic         mon_sel;
    logic         cos_edge;
    logic         pace_auto;

    assign sel   = pair_sel_e'(cfg_pair_sel);
    assign pin_n = {dsr_n_in, cts_n_in};
    assign tx_st = '{busy: tx_char_busy, stop_done: tx_stop_done};

    generate
        for (genvar l = 0; l < N_LANES; l++) begin : g_lane
            hwflow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
                .clk     (clk),
                .rst     (rst),
                .d_async (pin_n[l]),
                .q_sync  (mon_sync[l])
            );
        end
    endgenerate

    assign mon_sel = (sel == PAIR_TRM_SET) ? mon_sync[1] : mon_sync[0];

    hwflow_rx_pace #(.LVL_W(LVL_W)) u_pace (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (cfg_auto_rts_en),
        .fifo_lvl (rx_fifo_lvl),
        .trig_lvl (cfg_trig_lvl),
        .hyst     (cfg_hyst),
        .state    (pace_state)
    );

    hwflow_tx_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (cfg_auto_cts_en),
        .mon_high (mon_sel),
        .tx_st    (tx_st),
        .hold     (tx_hold)
    );

    hwflow_cos u_cos (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .mon_a     (mon_sync[0]),
        .mon_b     (mon_sync[1]),
        .clr       (msr_read),
        .edge_seen (cos_edge),
        .flag      (cos_flag)
    );

    assign pace_auto = cfg_auto_rts_en;

    always_comb begin
        rts_n_out = ~sw_rts;
        dtr_n_out = ~sw_dtr;
        if (pace_auto) begin
            if (sel == PAIR_TRM_SET) dtr_n_out = (pace_state == FLOW_PAUSED);
            else                     rts_n_out = (pace_state == FLOW_PAUSED);
        end
    end
endmodule

// File: rtl/hwflow_ctrl_chk.sv
module hwflow_ctrl_chk #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_pair_sel,
    input logic             cfg_auto_rts_en,
    input logic             cfg_auto_cts_en,
    input logic [LVL_W-1:0] cfg_trig_lvl,
    input logic [LVL_W-1:0] rx_fifo_lvl,
    input logic             tx_char_busy,
    input logic             tx_stop_done,
    input logic             msr_read,
    input logic             rts_n_out,
    input logic             tx_hold,
    input logic             cos_flag,
    input logic             mon_sel,
    input logic             cos_edge
);
    p_pause_over_trig_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_auto_rts_en && !cfg_pair_sel && rx_fifo_lvl > cfg_trig_lvl)
        ##1 (cfg_auto_rts_en && !cfg_pair_sel) |-> rts_n_out);

    p_pause_kept_in_band_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_auto_rts_en && !cfg_pair_sel && rts_n_out && rx_fifo_lvl >= cfg_trig_lvl)
        ##1 (cfg_auto_rts_en && !cfg_pair_sel) |-> rts_n_out);

    p_no_mid_char_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_char_busy && !tx_stop_done && !tx_hold) |=> !tx_hold);

    p_resume_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_auto_cts_en || !mon_sel) |=> !tx_hold);

    p_edge_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        cos_edge |=> cos_flag);

    p_read_clears_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (msr_read && !cos_edge) |=> !cos_flag);
endmodule

bind hwflow_ctrl hwflow_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_pair_sel    (cfg_pair_sel),
    .cfg_auto_rts_en (cfg_auto_rts_en),
    .cfg_auto_cts_en (cfg_auto_cts_en),
    .cfg_trig_lvl    (cfg_trig_lvl),
    .rx_fifo_lvl     (rx_fifo_lvl),
    .tx_char_busy    (tx_char_busy),
    .tx_stop_done    (tx_stop_done),
    .msr_read        (msr_read),
    .rts_n_out       (rts_n_out),
    .tx_hold         (tx_hold),
    .cos_flag        (cos_flag),
    .mon_sel         (mon_sel),
    .cos_edge        (cos_edge)
);

// File: tb/hwflow_ctrl_bench.sv
module hwflow_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // Vector table: level, trigger, hysteresis, auto enable, sw bit, expected rts_n_out
    localparam int V_LVL [NV] = '{ 0, 20, 21, 15, 12, 11, 32,  1,  0, 32, 32, 32};
    localparam int V_TRG [NV] = '{20, 20, 20, 20, 20, 20, 20,  4,  4, 20, 20, 32};
    localparam int V_HYS [NV] = '{ 8,  8,  8,  8,  8,  8,  8, 10, 10,  8,  8,  8};
    localparam int V_AUT [NV] = '{ 1,  1,  1,  1,  1,  1,  1,  1,  1,  0,  0,  1};
    localparam int V_SW  [NV] = '{ 0,  0,  0,  0,  0,  0,  0,  0,  0,  1,  0,  0};
    localparam int V_EXP [NV] = '{ 0,  0,  1,  1,  1,  0,  1,  1,  0,  0,  1,  0};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_pair_sel = 1'b0;
    logic       cfg_auto_rts_en = 1'b1;
    logic       cfg_auto_cts_en = 1'b1;
    logic [5:0] cfg_trig_lvl = 6'd20;
    logic [5:0] cfg_hyst = 6'd8;
    logic       sw_rts = 1'b0;
    logic       sw_dtr = 1'b0;
    logic [5:0] rx_fifo_lvl = 6'd0;
    logic       cts_n_in = 1'b0;
    logic       dsr_n_in = 1'b0;
    logic       tx_char_busy = 1'b0;
    logic       tx_stop_done = 1'b0;
    logic       msr_read = 1'b0;
    logic       rts_n_out, dtr_n_out, tx_hold, cos_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwflow_ctrl u_hwflow_ctrl (
        .clk(clk), .rst(rst), .cfg_pair_sel(cfg_pair_sel),
        .cfg_auto_rts_en(cfg_auto_rts_en), .cfg_auto_cts_en(cfg_auto_cts_en),
        .cfg_trig_lvl(cfg_trig_lvl), .cfg_hyst(cfg_hyst),
        .sw_rts(sw_rts), .sw_dtr(sw_dtr), .rx_fifo_lvl(rx_fifo_lvl),
        .cts_n_in(cts_n_in), .dsr_n_in(dsr_n_in),
        .tx_char_busy(tx_char_busy), .tx_stop_done(tx_stop_done),
        .msr_read(msr_read), .rts_n_out(rts_n_out), .dtr_n_out(dtr_n_out),
        .tx_hold(tx_hold), .cos_flag(cos_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic read_status();
        msr_read = 1'b1;
        step(1);
        msr_read = 1'b0;
    endtask

    initial begin
        step(3);
        chk("R10 rts_n", int'(rts_n_out), 0);
        chk("R10 hold", int'(tx_hold), 0);
        chk("R10 flag", int'(cos_flag), 0);
        rst = 1'b0;
        step(2);

        // Receive pacing vectors (R1, R2, R3)
        for (int v = 0; v < NV; v++) begin
            rx_fifo_lvl     = 6'(V_LVL[v]);
            cfg_trig_lvl    = 6'(V_TRG[v]);
            cfg_hyst        = 6'(V_HYS[v]);
            cfg_auto_rts_en = V_AUT[v][0];
            sw_rts          = V_SW[v][0];
            step(1);
            chk($sformatf("R1/R2/R3 vector %0d rts_n", v), int'(rts_n_out), V_EXP[v]);
        end
        rx_fifo_lvl = 6'd0;
        step(1);

        // R4 / R7: monitored input high, idle transmitter
        cts_n_in = 1'b1;
        step(2);
        chk("R4 hold not before third edge", int'(tx_hold), 0);
        step(1);
        chk("R4 hold raised", int'(tx_hold), 1);
        chk("R7 flag set", int'(cos_flag), 1);
        read_status();
        chk("R8 flag cleared", int'(cos_flag), 0);

        // R6: pin back low
        cts_n_in = 1'b0;
        step(3);
        chk("R6 hold released", int'(tx_hold), 0);
        chk("R7 flag on falling pin", int'(cos_flag), 1);
        read_status();

        // R5: character in progress
        tx_char_busy = 1'b1;
        cts_n_in = 1'b1;
        step(5);
        chk("R5 no hold mid-character", int'(tx_hold), 0);
        tx_stop_done = 1'b1;
        step(1);
        tx_stop_done = 1'b0;
        tx_char_busy = 1'b0;
        chk("R5 hold at stop bit", int'(tx_hold), 1);

        // R6: disabling automatic gating releases hold
        cfg_auto_cts_en = 1'b0;
        step(1);
        chk("R6 hold off when disabled", int'(tx_hold), 0);
        cfg_auto_cts_en = 1'b1;
        step(1);
        chk("R4 hold back when re-enabled", int'(tx_hold), 1);

        // R7: set wins over simultaneous clear
        read_status();
        cts_n_in = 1'b0;
        step(2);
        msr_read = 1'b1;
        step(1);
        msr_read = 1'b0;
        chk("R7 set beats clear", int'(cos_flag), 1);
        read_status();
        chk("R8 clear after priority case", int'(cos_flag), 0);

        // R9: alternate pair
        cfg_pair_sel = 1'b1;
        sw_rts = 1'b1;
        cfg_trig_lvl = 6'd20;
        rx_fifo_lvl = 6'd32;
        step(1);
        chk("R9 dtr_n paced", int'(dtr_n_out), 1);
        chk("R9 rts_n follows software", int'(rts_n_out), 0);
        cts_n_in = 1'b1;
        step(4);
        chk("R9 cts ignored hold", int'(tx_hold), 0);
        chk("R9 cts ignored flag", int'(cos_flag), 0);
        dsr_n_in = 1'b1;
        step(3);
        chk("R9 dsr raises hold", int'(tx_hold), 1);
        chk("R9 dsr sets flag", int'(cos_flag), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule